// File: doc/BRIEF.md
# Two-Wire Memory Slave Bus Engine

This block is the bus-facing front end of a serial memory that sits on a two-wire clock/data bus as a slave. It samples the raw clock and data lines in the system clock domain and cleans them with a synchronizer and a majority filter. From the cleaned lines it recognises start and stop conditions and receives the device-select byte. It accepts that byte when the type code matches and one strap bit equals the strap pin. The remaining two select bits choose one of four internal 256-byte blocks.

After a write-direction select, every byte the master sends is passed downstream with a one-cycle valid strobe. The first of these bytes is flagged as the word address. After a read-direction select, the engine takes a byte from the downstream side with a one-cycle take strobe and shifts it out MSB first. It continues for as long as the master acknowledges. The engine drives only an open-drain pull-down enable for the data line. While the downstream side reports a write cycle in progress, the engine stays silent to its own address.

Top module: `twi_mem_slave`

## Requirements
- R1: A data-line fall while the clock is high (start) restarts select-byte reception from any state, even in the middle of a byte. A data-line rise while the clock is high (stop) returns the engine to idle, releases the data line and pulses `bus_stop` for one cycle.
- R2: The select byte is received MSB first. Bits 7..4 must equal `1010`, bit 3 must equal `strap_a2`, bits 2..1 give `blk_sel`, and bit 0 gives `is_read` (1 = read, 0 = write). On acceptance, `sel_ok` pulses once with `blk_sel` and `is_read` valid.
- R3: A select byte with a wrong type code or a wrong strap bit is not acknowledged. Later bytes then produce no strobe and no acknowledge until the next start.
- R4: While `wr_busy` is high when the eighth select bit is sampled, the select byte is not acknowledged and `sel_ok` stays low.
- R5: The engine acknowledges by pulling the data line low (`sda_oe` = 1) for the whole ninth clock. It releases the line after the ninth clock falls. After reset `sda_oe` is 0.
- R6: In write direction, every received byte is acknowledged and pulses `wr_valid` with `wr_data`. `wr_is_addr` is 1 for the first byte after the select byte and 0 for the bytes that follow.
- R7: In read direction, `rd_take` pulses when a byte is taken from `rd_data`. The byte is then sent MSB first, with `sda_oe` = 1 for each 0 bit.
- R8: After each read byte the engine releases the line for the ninth clock. A low level from the master starts the next byte with another `rd_take`. A high level makes the engine stay released, with no further `rd_take`, until a start or stop.
- R9: A low pulse on the data line that lasts one system clock is filtered out and is not seen as a start.
- R10: `sda_oe` changes only while the filtered clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| strap_a2 | input | 1 | Strap level compared with select bit 3 |
| wr_busy | input | 1 | Downstream write cycle in progress |
| rd_data | input | 8 | Next read byte from downstream |
| sda_oe | output | 1 | 1 pulls the data line low |
| sel_ok | output | 1 | Strobe: select byte accepted |
| blk_sel | output | 2 | Page block from select bits 2..1 |
| is_read | output | 1 | Direction of the accepted select |
| wr_valid | output | 1 | Strobe: a write byte was received |
| wr_data | output | 8 | Received write byte |
| wr_is_addr | output | 1 | Received byte is the word address |
| rd_take | output | 1 | Strobe: read byte consumed |
| bus_stop | output | 1 | Strobe: stop condition seen |

## Verification
Two events can land on the same stretch of bus time. A start can arrive while a byte is half shifted in, and `wr_busy` can be raised at the moment the select byte completes. The bench provokes the first by cutting a select byte off after four bits with a new start. It then expects a clean acknowledge for the full select byte that follows and no stray write strobe. It provokes the second by holding `wr_busy` high across a correctly addressed select. It expects a released line during the ninth clock and no `sel_ok`; the checker also ties every `sel_ok` to a low busy level in the cycle before.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_RX, ST_PREACK, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } eng_state_t;

  // select byte accepted: type code, strap bit, not busy
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [3:0] code,
                                    input logic strap,
                                    input logic busy);
    return (b[7:4] == code) && (b[3] == strap) && !busy;
  endfunction

  function automatic logic [1:0] block_of(input logic [BYTE_W-1:0] b);
    return b[2:1];
  endfunction
endpackage

// File: rtl/twi_deglitch.sv
module twi_deglitch #(
  parameter int SYNC = 2,
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(TAPS + 1);

  logic [SYNC-1:0] sy;
  logic [TAPS-1:0] hist;
  logic [CW-1:0]   ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CW'(hist[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '1;
      hist <= '1;
      dout <= 1'b1;
    end else begin
      sy   <= {sy[SYNC-2:0], din};
      hist <= {hist[TAPS-2:0], sy[SYNC-1]};
      dout <= (ones > CW'(TAPS / 2));
    end
  end
endmodule

// File: rtl/twi_events.sv
module twi_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_a2,
  input  logic              wr_busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              sel_ok,
  output logic [1:0]        blk_sel,
  output logic              is_read,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_is_addr,
  output logic              rd_take,
  output logic              bus_stop
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] raw_l, filt_l;
  assign raw_l = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    twi_deglitch #(.SYNC(SYNC_STAGES), .TAPS(FILT_TAPS)) u_dg (
      .clk(clk), .rst_n(rst_n), .din(raw_l[g]), .dout(filt_l[g]));
  end

  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_f = filt_l[0];
  assign sda_f = filt_l[1];

  twi_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] rx_byte;
  logic              first_q, mack_ok;
  logic              ignoring_bus;

  assign rx_byte      = {shreg[BYTE_W-2:0], sda_f};
  assign ignoring_bus = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      first_q    <= 1'b0;
      mack_ok    <= 1'b0;
      sda_oe     <= 1'b0;
      sel_ok     <= 1'b0;
      blk_sel    <= '0;
      is_read    <= 1'b0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_is_addr <= 1'b0;
      rd_take    <= 1'b0;
      bus_stop   <= 1'b0;
    end else begin
      sel_ok   <= 1'b0;
      wr_valid <= 1'b0;
      rd_take  <= 1'b0;
      bus_stop <= 1'b0;
      if (start_ev) begin
        state  <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        bus_stop <= 1'b1;
      end else begin
        unique case (state)
          ST_DEV: if (scl_rise) begin
            shreg <= rx_byte;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (addr_hit(rx_byte, TYPE_CODE, strap_a2, wr_busy)) begin
                blk_sel <= block_of(rx_byte);
                is_read <= rx_byte[0];
                sel_ok  <= 1'b1;
                first_q <= 1'b1;
                state   <= ST_PREACK;
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RX: if (scl_rise) begin
            shreg <= rx_byte;
            if (cnt == LAST_BIT) begin
              cnt        <= '0;
              wr_valid   <= 1'b1;
              wr_data    <= rx_byte;
              wr_is_addr <= first_q;
              first_q    <= 1'b0;
              state      <= ST_PREACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PREACK: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            if (is_read) begin
              shreg   <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              rd_take <= 1'b1;
              cnt     <= '0;
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_ok <= ~sda_f;
            if (scl_fall) begin
              if (mack_ok) begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                rd_take <= 1'b1;
                cnt     <= '0;
                state   <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic wr_busy,
  input logic sel_ok,
  input logic wr_valid,
  input logic rd_take,
  input logic ignoring
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f); // R10
  AST_BUSY_BLOCKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> !$past(wr_busy)); // R4
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R1
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ok, wr_valid, rd_take})); // R6
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f),
  .start_ev(start_ev), .stop_ev(stop_ev), .wr_busy(wr_busy),
  .sel_ok(sel_ok), .wr_valid(wr_valid), .rd_take(rd_take),
  .ignoring(ignoring_bus));

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int HP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_a2 = 1'b1, wr_busy = 1'b0;
  logic [7:0] rd_val = 8'hC3;
  logic sda_oe, sel_ok, is_read, wr_valid, wr_is_addr, rd_take, bus_stop;
  logic [1:0] blk_sel;
  logic [7:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, stop_cnt = 0, take_cnt = 0;
  logic [8:0] wr_q[$];
  logic [2:0] sel_q[$];
  logic done = 1'b0;

  always #5 clk = ~clk;

  twi_mem_slave i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_a2(strap_a2), .wr_busy(wr_busy), .rd_data(rd_val),
    .sda_oe(sda_oe), .sel_ok(sel_ok), .blk_sel(blk_sel), .is_read(is_read),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_is_addr(wr_is_addr),
    .rd_take(rd_take), .bus_stop(bus_stop));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor and downstream read model
  always @(negedge clk) if (rst_n) begin
    if (wr_valid) begin
      if (wr_q.size() == 0) chk(1'b0, "R6 unexpected write strobe", {wr_is_addr, wr_data}, 0);
      else begin
        logic [8:0] e;
        e = wr_q.pop_front();
        chk({wr_is_addr, wr_data} == e, "R6 write byte", {wr_is_addr, wr_data}, e);
      end
    end
    if (sel_ok) begin
      if (sel_q.size() == 0) chk(1'b0, "R2 unexpected select", {blk_sel, is_read}, 0);
      else begin
        logic [2:0] e;
        e = sel_q.pop_front();
        chk({blk_sel, is_read} == e, "R2 select fields", {blk_sel, is_read}, e);
      end
    end
    if (bus_stop) stop_cnt++;
    if (rd_take) begin
      take_cnt++;
      rd_val <= rd_val + 8'h11;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b;
    tick(HP);
    scl_m = 1'b1;
    tick(HP / 2);
    s = sda_line;
    tick(HP / 2);
    scl_m = 1'b0;
    tick(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop_t();
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  // sends a byte; ack = slave pulled low in ninth clock; clash = a 1 bit read low
  task automatic send_byte(input logic [7:0] b, output logic ack, output logic clash);
    logic s;
    clash = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(b[i], s);
      if (b[i] && !s) clash = 1'b1;
    end
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic m_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~m_ack, s);
    sda_m = 1'b1;
  endtask

  initial begin
    logic ack, clash;
    logic [7:0] d;
    int n;
    tick(5);
    chk(sda_oe == 1'b0, "R5 reset release", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);

    // R2 R5 R6: write select, block 2, word address, two data bytes
    bus_start();
    sel_q.push_back({2'b10, 1'b0});
    send_byte(8'b1010_1_10_0, ack, clash);
    chk(ack, "R2 select acknowledged", ack, 1);
    wr_q.push_back({1'b1, 8'h3C});
    send_byte(8'h3C, ack, clash);
    chk(ack, "R6 word address ack", ack, 1);
    wr_q.push_back({1'b0, 8'hA5});
    send_byte(8'hA5, ack, clash);
    chk(ack && !clash, "R5 ack then release", {ack, clash}, 2);
    wr_q.push_back({1'b0, 8'h5A});
    send_byte(8'h5A, ack, clash);
    chk(ack, "R6 data ack", ack, 1);
    n = stop_cnt;
    bus_stop_t();
    chk(stop_cnt == n + 1, "R1 stop strobe", stop_cnt, n + 1);

    // R3: strap bit mismatch, then a further byte is ignored
    bus_start();
    send_byte(8'b1010_0_00_0, ack, clash);
    chk(!ack, "R3 strap mismatch no ack", ack, 0);
    send_byte(8'h77, ack, clash);
    chk(!ack, "R3 ignored until start", ack, 0);
    bus_stop_t();

    // R3: type code mismatch
    bus_start();
    send_byte(8'b1011_1_00_0, ack, clash);
    chk(!ack, "R3 type mismatch no ack", ack, 0);
    bus_stop_t();

    // R4: busy downstream
    wr_busy = 1'b1;
    bus_start();
    send_byte(8'b1010_1_01_0, ack, clash);
    chk(!ack, "R4 busy no ack", ack, 0);
    bus_stop_t();
    wr_busy = 1'b0;

    // R1: start in the middle of a byte restarts reception
    bus_start();
    for (int i = 0; i < 4; i++) clock_bit(1'b1, d[0]);
    bus_start();
    sel_q.push_back({2'b01, 1'b0});
    send_byte(8'b1010_1_01_0, ack, clash);
    chk(ack, "R1 restart mid-byte", ack, 1);
    wr_q.push_back({1'b1, 8'h81});
    send_byte(8'h81, ack, clash);
    chk(ack, "R6 word address after restart", ack, 1);

    // R1: stop in the middle of a byte, then bytes without start are ignored
    for (int i = 0; i < 3; i++) clock_bit(1'b0, d[0]);
    bus_stop_t();
    scl_m = 1'b0; tick(4);
    send_byte(8'h55, ack, clash);
    chk(!ack, "R1 idle after stop", ack, 0);
    scl_m = 1'b1; sda_m = 1'b1; tick(HP);

    // R7 R8: read from block 3 with master ack then nack
    bus_start();
    sel_q.push_back({2'b11, 1'b1});
    send_byte(8'b1010_1_11_1, ack, clash);
    chk(ack, "R2 read select ack", ack, 1);
    n = take_cnt;
    recv_byte(d, 1'b1);
    chk(d == 8'hC3, "R7 first read byte", d, 8'hC3);
    recv_byte(d, 1'b0);
    chk(d == 8'hD4, "R8 byte after master ack", d, 8'hD4);
    recv_byte(d, 1'b0);
    chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    chk(take_cnt == n + 2, "R8 no take after nack", take_cnt, n + 2);
    bus_stop_t();

    // R9: one-clock data glitch while clock high is not a start
    tick(HP);
    sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(HP);
    scl_m = 1'b0; tick(4);
    send_byte(8'b1010_1_00_0, ack, clash);
    chk(!ack, "R9 glitch rejected", ack, 0);
    scl_m = 1'b1; sda_m = 1'b1; tick(HP);

    chk(wr_q.size() == 0 && sel_q.size() == 0, "R6 scoreboard drained",
        wr_q.size() + sel_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule